// File: doc/BRIEF.md
# SPI Master Transfer Engine

This block is a byte-wide SPI master. A producer writes bytes into a transmit queue, and the control side sets a total byte count and a transmit byte count. It then pulses a start input. The engine sends each byte on `mosi` while it captures `miso`. Once the transmit byte count has run out, it clocks filler bytes of 0x00, so a read-only phase needs no dummy data in the queue. Each received byte goes into a receive queue, unless discard mode is on. When the last byte finishes, a sticky completion flag is set. Writing a one to the clear input drops the flag, and the flag drives the interrupt output only while its enable is high.

The serial clock advances only on `bit_tick`, a one-cycle enable from an external divider. Each byte takes 16 ticks, one per half period. Clock polarity, clock phase, bit order, the chip-select index, chip-select polarity and manual chip-select level are plain configuration pins.

Both queues have stream ports. The transmit side accepts a byte in a cycle where `tx_valid` and `tx_ready` are both high, and `tx_ready` is low only while the queue is full. The receive side offers `rx_data` whenever `rx_valid` is high, and a byte leaves the queue in a cycle where `rx_valid` and `rx_ready` are both high. The engine itself never waits on the receive consumer. A byte that arrives while the receive queue is full is lost and the overflow flag records it.

Top module: `spi_xfer_engine`

## Requirements
- R1: After reset `busy`, `done`, `irq`, `rx_ovf`, `rx_valid`, `tx_level` and `rx_level` are 0, `tx_ready` is 1, `sclk` equals `cfg_cpol` and every `cs_o` pin is at its inactive level.
- R2: The transmit queue holds DEPTH (128) bytes. `tx_level` counts stored bytes, and `tx_ready` is 0 exactly when `tx_level` equals DEPTH. An offered byte is ignored while the queue is full.
- R3: A transfer clocks exactly `burst_len` bytes of 8 bits. `sclk` rests at `cfg_cpol` and toggles once per `bit_tick` while busy. With `cfg_cpha`=0 both sides sample on the first (leading) edge of each bit. With `cfg_cpha`=1 both sides sample on the second (trailing) edge.
- R4: With `cfg_lsb_first`=1 bit 0 of each byte is shifted first, and with 0 bit 7 is shifted first. The same order applies to transmit and receive.
- R5: Byte n of a burst (counting from 0) is taken from the transmit queue when n < `tx_len` and the queue is non-empty. Otherwise 0x00 is sent and the queue is untouched.
- R6: Unless discarding, each received byte enters the receive queue when its eighth bit completes. `rx_valid` is high while `rx_level` is non-zero, and a handshake removes the oldest byte.
- R7: With `cfg_rx_discard`=1 no received byte enters the receive queue.
- R8: A byte that completes while the receive queue is full is dropped and sets sticky `rx_ovf`. A high on `ovf_clr` clears it.
- R9: `start` while idle latches `burst_len` and `tx_len`, and `busy` rises on the next edge. `start` while busy has no effect. `start` with `burst_len`=0 clocks nothing and sets `done` at once.
- R10: `busy` falls and `done` rises on the same edge, when the last byte completes. A high on `done_clr` clears `done`, but a completion in that same cycle wins.
- R11: `irq` equals `done` AND `done_ie`.
- R12: Only `cs_o[cs_sel]` is ever asserted. All other pins stay inactive, where active means 1 if `cs_active_high`=1 and 0 otherwise. With `cs_manual`=1 the selected pin carries `cs_level` directly. With `cs_manual`=0 it is active exactly while `busy`.
- R13: `txf_flush` and `rxf_flush` each empty their own queue in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| bit_tick | input | 1 | half-period enable from the divider |
| cfg_cpol | input | 1 | serial clock idle level |
| cfg_cpha | input | 1 | 1 = sample on trailing edge |
| cfg_lsb_first | input | 1 | 1 = bit 0 first |
| cfg_rx_discard | input | 1 | 1 = do not store received bytes |
| cs_sel | input | $clog2(NCS) | chip-select index |
| cs_active_high | input | 1 | chip-select active level |
| cs_manual | input | 1 | 1 = selected pin follows cs_level |
| cs_level | input | 1 | manual chip-select level |
| burst_len | input | CNT_W | total bytes in a transfer |
| tx_len | input | CNT_W | bytes taken from the transmit queue |
| start | input | 1 | start pulse |
| done_clr | input | 1 | clear completion flag |
| done_ie | input | 1 | completion interrupt enable |
| ovf_clr | input | 1 | clear overflow flag |
| txf_flush | input | 1 | empty transmit queue |
| rxf_flush | input | 1 | empty receive queue |
| tx_valid | input | 1 | transmit byte offered |
| tx_data | input | 8 | transmit byte |
| tx_ready | output | 1 | transmit queue not full |
| rx_valid | output | 1 | receive byte available |
| rx_data | output | 8 | oldest received byte |
| rx_ready | input | 1 | consumer takes rx_data |
| busy | output | 1 | transfer in progress |
| done | output | 1 | sticky completion flag |
| irq | output | 1 | completion interrupt |
| rx_ovf | output | 1 | sticky receive overflow |
| tx_level | output | $clog2(DEPTH+1) | transmit queue fill |
| rx_level | output | $clog2(DEPTH+1) | receive queue fill |
| sclk | output | 1 | serial clock |
| mosi | output | 1 | serial data out |
| miso | input | 1 | serial data in |
| cs_o | output | NCS | chip-select pins |

## Verification
The completion of the last byte and a `done_clr` pulse can fall in the same cycle. The bench provokes this by holding `done_clr` high for the whole length of a transfer while `done` is already set. A cycle-level model updates its expected flag from the observed fall of `busy` and from the clear input, and it gives set priority. It compares `done` and `irq` on every clock, so `done` must read 0 during the transfer and 1 straight after the final edge. The same model follows chip-select pins and the idle clock level every cycle, while a bit-level slave model checks the serial bytes in both directions.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic lsb_first;
  } frame_cfg_t;

  // Position within a byte of the idx-th shifted bit.
  function automatic logic [2:0] bit_slot(input logic [2:0] idx, input logic lsb_first);
    return lsb_first ? idx : ~idx;
  endfunction
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int DEPTH = 128,
  parameter int WIDTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             full,
  output logic             empty,
  output logic [LW-1:0]    level
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      level <= level + LW'(do_push) - LW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr] <= wdata;
  end

  // R2
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  // R2
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop && !flush) |=> full);
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_xfer_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  frame_cfg_t       cfg,
  input  logic             start,
  input  logic [CNT_W-1:0] burst_len,
  input  logic [CNT_W-1:0] tx_len,
  input  logic             txf_empty,
  input  byte_t            txf_data,
  output logic             txf_pop,
  input  logic             miso,
  output logic             rx_push,
  output byte_t            rx_byte,
  output logic             busy,
  output logic             sclk,
  output logic             mosi,
  output logic             done_pulse
);
  localparam logic [3:0] LAST_HALF = 4'd15;

  frame_cfg_t       cfg_q;
  logic             busy_r, sclk_r;
  logic [3:0]       half;
  byte_t            txb, rxb, rx_next, fetched;
  logic [CNT_W-1:0] bytes_left, tx_left, left_src;
  logic             launch, zero_launch, byte_end, more, fetch, take, sample;
  logic [3:0]       half_m1;
  logic [2:0]       idx;

  assign launch      = start && !busy_r && (burst_len != '0);
  assign zero_launch = start && !busy_r && (burst_len == '0);
  assign byte_end    = busy_r && bit_tick && (half == LAST_HALF);
  assign more        = byte_end && (bytes_left != CNT_W'(1));
  assign fetch       = launch || more;
  // R5: byte source is the queue only inside the transmit count
  assign left_src    = launch ? tx_len : tx_left;
  assign take        = fetch && (left_src != '0) && !txf_empty;
  assign fetched     = take ? txf_data : '0;
  assign txf_pop     = take;

  // R3: bit index; with trailing-edge sampling the data moves on leading edges
  assign half_m1 = half - 4'd1;
  assign idx     = cfg_q.cpha ? ((half == 4'd0) ? 3'd0 : half_m1[3:1]) : half[3:1];
  assign sample  = busy_r && bit_tick && (cfg_q.cpha ? half[0] : !half[0]);

  always_comb begin
    rx_next = rxb;
    // R4
    if (sample) rx_next[bit_slot(idx, cfg_q.lsb_first)] = miso;
  end

  assign rx_push    = byte_end;
  assign rx_byte    = rx_next;
  assign busy       = busy_r;
  assign sclk       = busy_r ? sclk_r : cfg.cpol;
  assign mosi       = busy_r ? txb[bit_slot(idx, cfg_q.lsb_first)] : 1'b0;
  assign done_pulse = zero_launch || (byte_end && (bytes_left == CNT_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_r     <= 1'b0;
      sclk_r     <= 1'b0;
      half       <= '0;
      txb        <= '0;
      rxb        <= '0;
      bytes_left <= '0;
      tx_left    <= '0;
      cfg_q      <= '0;
    end else if (launch) begin
      busy_r     <= 1'b1;
      sclk_r     <= cfg.cpol;
      half       <= '0;
      cfg_q      <= cfg;
      bytes_left <= burst_len;
      tx_left    <= (left_src != '0) ? left_src - CNT_W'(1) : '0;
      txb        <= fetched;
      rxb        <= '0;
    end else if (busy_r && bit_tick) begin
      sclk_r <= ~sclk_r;
      half   <= half + 4'd1;
      rxb    <= rx_next;
      if (byte_end) begin
        rxb <= '0;
        if (more) begin
          bytes_left <= bytes_left - CNT_W'(1);
          tx_left    <= (left_src != '0) ? left_src - CNT_W'(1) : '0;
          txb        <= fetched;
        end else begin
          busy_r <= 1'b0;
        end
      end
    end
  end

  // R3
  sclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(bit_tick)) |-> $stable(sclk));

  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(bytes_left) || $past(bit_tick));
endmodule

// File: rtl/spi_cs_drive.sv
module spi_cs_drive #(
  parameter int NCS = 4,
  localparam int SW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic [SW-1:0]  sel,
  input  logic           active_high,
  input  logic           manual,
  input  logic           level,
  input  logic           busy,
  output logic [NCS-1:0] cs_o
);
  logic sel_val;
  assign sel_val = manual ? level : (busy ? active_high : ~active_high);

  // R12
  for (genvar i = 0; i < NCS; i++) begin : g_pin
    assign cs_o[i] = (sel == SW'(i)) ? sel_val : ~active_high;
  end
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_xfer_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int CNT_W = 24,
  parameter int NCS   = 4,
  localparam int SW = (NCS > 1) ? $clog2(NCS) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             cfg_cpol,
  input  logic             cfg_cpha,
  input  logic             cfg_lsb_first,
  input  logic             cfg_rx_discard,
  input  logic [SW-1:0]    cs_sel,
  input  logic             cs_active_high,
  input  logic             cs_manual,
  input  logic             cs_level,
  input  logic [CNT_W-1:0] burst_len,
  input  logic [CNT_W-1:0] tx_len,
  input  logic             start,
  input  logic             done_clr,
  input  logic             done_ie,
  input  logic             ovf_clr,
  input  logic             txf_flush,
  input  logic             rxf_flush,
  input  logic             tx_valid,
  input  logic [7:0]       tx_data,
  output logic             tx_ready,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  input  logic             rx_ready,
  output logic             busy,
  output logic             done,
  output logic             irq,
  output logic             rx_ovf,
  output logic [LW-1:0]    tx_level,
  output logic [LW-1:0]    rx_level,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic [NCS-1:0]   cs_o
);
  frame_cfg_t cfg;
  logic  txf_full, txf_empty, txf_pop, rxf_full, rxf_empty;
  logic  core_rx_push, rx_store, done_pulse, done_r, ovf_r;
  byte_t txf_data, core_rx_byte;

  assign cfg = '{cpol: cfg_cpol, cpha: cfg_cpha, lsb_first: cfg_lsb_first};

  spi_byte_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_txf (
    .clk(clk), .rst_n(rst_n), .flush(txf_flush),
    .push(tx_valid), .wdata(tx_data),
    .pop(txf_pop), .rdata(txf_data),
    .full(txf_full), .empty(txf_empty), .level(tx_level)
  );

  spi_shift_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .cfg(cfg),
    .start(start), .burst_len(burst_len), .tx_len(tx_len),
    .txf_empty(txf_empty), .txf_data(txf_data), .txf_pop(txf_pop),
    .miso(miso), .rx_push(core_rx_push), .rx_byte(core_rx_byte),
    .busy(busy), .sclk(sclk), .mosi(mosi), .done_pulse(done_pulse)
  );

  // R6 R7
  assign rx_store = core_rx_push && !cfg_rx_discard;

  spi_byte_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_rxf (
    .clk(clk), .rst_n(rst_n), .flush(rxf_flush),
    .push(rx_store), .wdata(core_rx_byte),
    .pop(rx_ready), .rdata(rx_data),
    .full(rxf_full), .empty(rxf_empty), .level(rx_level)
  );

  spi_cs_drive #(.NCS(NCS)) u_cs (
    .sel(cs_sel), .active_high(cs_active_high), .manual(cs_manual),
    .level(cs_level), .busy(busy), .cs_o(cs_o)
  );

  assign tx_ready = !txf_full;
  assign rx_valid = !rxf_empty;

  // R8 R10: set has priority over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_r <= 1'b0;
      ovf_r  <= 1'b0;
    end else begin
      if (done_pulse)    done_r <= 1'b1;
      else if (done_clr) done_r <= 1'b0;
      if (rx_store && rxf_full) ovf_r <= 1'b1;
      else if (ovf_clr)         ovf_r <= 1'b0;
    end
  end

  assign done   = done_r;
  assign rx_ovf = ovf_r;
  // R11
  assign irq    = done_r && done_ie;

  // R10
  done_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_ie |-> !irq);

  // R8
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ovf) |-> $past(rx_level) == LW'(DEPTH));

  // R12
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cs_manual) |-> (cs_o == {NCS{~cs_active_high}}));
endmodule

// File: tb/tb_spi_xfer_engine.sv
module tb_spi_xfer_engine;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 128;

  logic clk = 1'b0, rst_n = 1'b0, bit_tick = 1'b0;
  logic cfg_cpol = 0, cfg_cpha = 0, cfg_lsb_first = 0, cfg_rx_discard = 0;
  logic [1:0] cs_sel = 0;
  logic cs_active_high = 0, cs_manual = 0, cs_level = 0;
  logic [23:0] burst_len = 0, tx_len = 0;
  logic start = 0, done_clr = 0, done_ie = 0, ovf_clr = 0, txf_flush = 0, rxf_flush = 0;
  logic tx_valid = 0, rx_ready = 0, miso = 0;
  logic [7:0] tx_data = 0;
  logic tx_ready, rx_valid, busy, done, irq, rx_ovf, sclk, mosi;
  logic [7:0] rx_data, tx_level, rx_level;
  logic [3:0] cs_o;

  int vectors = 0, miscompares = 0, tick_div = 1;
  logic mon_en = 0;
  logic [7:0] slv_got[$], slv_sent[$], got_rx[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_xfer_engine dut (
    .clk, .rst_n, .bit_tick, .cfg_cpol, .cfg_cpha, .cfg_lsb_first, .cfg_rx_discard,
    .cs_sel, .cs_active_high, .cs_manual, .cs_level, .burst_len, .tx_len, .start,
    .done_clr, .done_ie, .ovf_clr, .txf_flush, .rxf_flush, .tx_valid, .tx_data,
    .tx_ready, .rx_valid, .rx_data, .rx_ready, .busy, .done, .irq, .rx_ovf,
    .tx_level, .rx_level, .sclk, .mosi, .miso, .cs_o
  );

  function automatic logic [2:0] slot(input int k);
    return cfg_lsb_first ? 3'(k) : 3'(7 - k);
  endfunction

  function automatic logic [7:0] gen(input int i);
    return 8'hA5 ^ 8'(i * 29);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cmp_q(input string req, input logic [7:0] act[$], input logic [7:0] exp[$]);
    chk({req, " count"}, act.size(), exp.size());
    foreach (exp[i]) if (i < act.size()) chk(req, act[i], exp[i]);
  endtask

  // bit tick generator
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      bit_tick = (cnt == 0);
      cnt = (cnt + 1) % tick_div;
    end
  end

  // bit-level slave: samples on the master's sampling edge, shifts its own byte
  initial begin
    logic prev_sclk = 0, prev_mosi = 0, prev_act = 0;
    logic [7:0] cap = 0, s_out;
    int k = 0, s_idx = 0;
    s_out = gen(0);
    forever begin
      @(negedge clk);
      if (prev_act && sclk !== prev_sclk) begin
        if ((prev_sclk == cfg_cpol) ^ cfg_cpha) begin
          cap[slot(k)] = prev_mosi;
          k++;
          if (k == 8) begin
            slv_got.push_back(cap);
            slv_sent.push_back(s_out);
            s_idx++;
            s_out = gen(s_idx);
            k = 0;
          end
        end
      end
      prev_act = (cs_o[cs_sel] == cs_active_high) && rst_n;
      if (!prev_act) begin k = 0; s_idx = 0; s_out = gen(0); end
      miso = s_out[slot(k)];
      prev_sclk = sclk;
      prev_mosi = mosi;
    end
  end

  // cycle-level reference model of flags, chip selects and idle clock
  initial begin
    logic exp_done = 0, prev_busy = 0;
    logic [3:0] exp_cs;
    forever begin
      @(posedge clk); #1;
      if (mon_en) begin
        if ((prev_busy && !busy) || (start && burst_len == 0 && !prev_busy)) exp_done = 1;
        else if (done_clr) exp_done = 0;
        chk("R10 done", done, exp_done);
        chk("R11 irq", irq, exp_done && done_ie);
        for (int i = 0; i < 4; i++)
          exp_cs[i] = (cs_sel == 2'(i)) ? (cs_manual ? cs_level : (busy ? cs_active_high : ~cs_active_high))
                                        : ~cs_active_high;
        chk("R12 cs", cs_o, exp_cs);
        if (!busy) chk("R3 idle sclk", sclk, cfg_cpol);
        prev_busy = busy;
      end
    end
  end

  task automatic push_tx(input logic [7:0] b);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1; tx_data = b;
    @(negedge clk);
    tx_valid = 0;
  endtask

  task automatic drain_rx();
    got_rx.delete();
    @(negedge clk);
    while (rx_valid) begin
      got_rx.push_back(rx_data);
      rx_ready = 1;
      @(negedge clk);
    end
    rx_ready = 0;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  task automatic run_xfer(input int burst, input int txn);
    slv_got.delete(); slv_sent.delete();
    @(negedge clk); burst_len = 24'(burst); tx_len = 24'(txn); start = 1;
    @(negedge clk); start = 0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [7:0] exp[$];
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 cs", cs_o, 4'hF);
    chk("R1 tx_ready", tx_ready, 1); chk("R1 rx_valid", rx_valid, 0); chk("R1 sclk", sclk, 0);
    rst_n = 1;
    @(negedge clk);
    mon_en = 1;
    chk("R1 levels", {tx_level, rx_level}, 0); chk("R1 ovf", rx_ovf, 0);

    // mode 0, MSB first, fast ticks
    push_tx(8'hA1); push_tx(8'hB2); push_tx(8'hC3);
    chk("R2 tx_level", tx_level, 3);
    run_xfer(3, 3);
    cmp_q("R3 R4 mosi mode0", slv_got, '{8'hA1, 8'hB2, 8'hC3});
    exp = slv_sent;
    drain_rx();
    cmp_q("R6 rx mode0", got_rx, exp);

    // mode 3, LSB first, slow ticks, zero filler after transmit count
    cfg_cpol = 1; cfg_cpha = 1; cfg_lsb_first = 1; tick_div = 3;
    push_tx(8'h5A); push_tx(8'h3C);
    run_xfer(5, 2);
    cmp_q("R4 R5 mosi mode3 lsb", slv_got, '{8'h5A, 8'h3C, 8'h00, 8'h00, 8'h00});
    exp = slv_sent;
    drain_rx();
    cmp_q("R6 rx mode3", got_rx, exp);

    // mode 1 with discard
    cfg_cpol = 0; cfg_cpha = 1; cfg_lsb_first = 0; cfg_rx_discard = 1; tick_div = 2;
    push_tx(8'h0F);
    run_xfer(2, 1);
    cmp_q("R7 mosi", slv_got, '{8'h0F, 8'h00});
    chk("R7 rx_level", rx_level, 0); chk("R7 rx_valid", rx_valid, 0);
    cfg_rx_discard = 0;

    // mode 2, transmit queue runs dry inside the transmit count
    cfg_cpol = 1; cfg_cpha = 0; tick_div = 1;
    push_tx(8'h77);
    run_xfer(3, 3);
    cmp_q("R5 underrun", slv_got, '{8'h77, 8'h00, 8'h00});
    chk("R5 tx_level", tx_level, 0);
    drain_rx();

    // bytes beyond the transmit count are left in the queue
    push_tx(8'h11); push_tx(8'h22); push_tx(8'h33);
    run_xfer(2, 1);
    cmp_q("R5 count limit", slv_got, '{8'h11, 8'h00});
    chk("R5 leftover", tx_level, 2);
    pulse(txf_flush);
    chk("R13 tx flush", tx_level, 0);
    drain_rx();

    // zero-length burst
    done_ie = 1;
    run_xfer(0, 0);
    chk("R9 zero burst bytes", slv_got.size(), 0);
    chk("R9 zero burst done", done, 1); chk("R11 irq on", irq, 1);
    pulse(done_clr);
    chk("R10 clear", done, 0);
    done_ie = 0;

    // completion and clear in the same cycle, start while busy ignored
    cfg_cpol = 0; cfg_cpha = 0; cs_sel = 1;
    run_xfer(0, 0);
    slv_got.delete();
    @(negedge clk); burst_len = 2; tx_len = 0; start = 1;
    @(negedge clk); start = 0; done_clr = 1;
    repeat (3) @(negedge clk);
    chk("R12 auto cs mid", cs_o, 4'b1101);
    burst_len = 10; start = 1;
    @(negedge clk); start = 0;
    while (busy) @(negedge clk);
    done_clr = 0;
    chk("R10 set wins", done, 1);
    repeat (2) @(negedge clk);
    chk("R9 ignored start", slv_got.size(), 2);
    chk("R11 irq gated", irq, 0);
    drain_rx();

    // manual chip select
    cs_manual = 1; cs_sel = 2; cs_active_high = 1; cs_level = 1;
    @(negedge clk);
    chk("R12 manual on", cs_o, 4'b0100);
    cs_level = 0;
    @(negedge clk);
    chk("R12 manual off", cs_o, 4'b0000);
    cs_manual = 0; cs_active_high = 0; cs_sel = 0;

    // transmit queue full
    for (int i = 0; i < DEPTH; i++) push_tx(8'(i));
    chk("R2 full level", tx_level, DEPTH);
    chk("R2 tx_ready", tx_ready, 0);
    @(negedge clk); tx_valid = 1; @(negedge clk); tx_valid = 0;
    chk("R2 ignored push", tx_level, DEPTH);
    pulse(txf_flush);

    // receive overflow
    run_xfer(DEPTH + 2, 0);
    chk("R3 long burst", slv_got.size(), DEPTH + 2);
    chk("R8 rx_level", rx_level, DEPTH);
    chk("R8 ovf", rx_ovf, 1);
    exp = slv_sent[0:DEPTH-1];
    drain_rx();
    cmp_q("R8 kept bytes", got_rx, exp);
    pulse(ovf_clr);
    chk("R8 ovf clear", rx_ovf, 0);

    // receive flush
    run_xfer(2, 0);
    chk("R6 rx_level", rx_level, 2);
    pulse(rxf_flush);
    chk("R13 rx flush", rx_level, 0);

    repeat (3) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule